// File: doc/BRIEF.md
# Token Ring Wireless Channel Arbiter

This block decides when one wireless interface may use a shared on-chip radio channel. All interfaces on the channel form a logical ring and pass a single token around it, so only one of them transmits at a time. While an interface holds the token it sends data flits, one per slot. It then hands the token to the next interface in the ring by sending a token flit.

The length of each holding period is not fixed. A fixed budget of slots is shared among all ring members. The share of each member follows the predicted demands that every member receives once per period in the same broadcast vector. Each member computes its own share from that vector. The share is rounded down, and the slots left over by rounding go to whoever holds the token when the vector arrives. The block counts the slots it uses and gives the token up when its share is spent or its transmit queue runs dry.

The controller has three states. WAIT: the token is held elsewhere. SEND: the token is held and slots are being used. RELEASE: a single cycle in which the token flit is emitted. Its transitions are:
- grant: WAIT to SEND, when a token flit addressed to this node arrives.
- exhaust: SEND to RELEASE, when the slot count reaches the share latched at grant or the queue is empty.
- handoff: RELEASE to WAIT, always after one cycle.
- reset entry: node 0 starts in SEND and every other node starts in WAIT.

Top module: `token_ring_arbiter`

## Requirements
- R1: After reset, node 0 holds the token and its share is the equal split, 96/12 = 8 slots (plus any remainder of that split). Other nodes start in WAIT.
- R2: `holding` is high from the cycle after a grant until the cycle after the token flit is emitted. `tx_en` is never high unless `holding` is high.
- R3: An incoming flit grants the token only if `tok_in_valid` is high, bits [31:28] equal 4'hA, and bits [7:4] equal this node's ID. Any other flit is ignored and does not change `holding`.
- R4: On release, `tok_out_valid` is high for exactly one cycle. The flit carries 4'hA in [31:28], the slots used in [14:8], the next ID, (ID+1) mod 12, in [7:4], and this node's ID in [3:0]. All other bits are zero.
- R5: When `dem_valid` is high, the node's next share becomes floor(96 * d_own / sum of all 12 demands). Demand i is `dem_vec[8i+7:8i]`.
- R6: If this node is the recorded token holder when the demand vector arrives, the remainder (96 minus the sum of all 12 rounded-down shares) is added to its share.
- R7: If all demands are zero, each node's share is 96/12 = 8.
- R8: In SEND, one slot is used per cycle (`tx_en` high) while the queue is non-empty and fewer slots than the share have been used. The share is latched at grant, so a demand vector that arrives during a hold applies only to the next hold.
- R9: A node whose share is zero spends one cycle in SEND with no transmission and then releases with a used count of 0.
- R10: If `q_nonempty` is low in SEND, the node releases in the next cycle, and the used count equals the slots actually sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dem_valid | input | 1 | Broadcast demand vector valid this cycle |
| dem_vec | input | 96 | Twelve 8-bit predicted demands, node i in bits [8i+7:8i] |
| tok_in_valid | input | 1 | A token flit is on the channel |
| tok_in_flit | input | 32 | Incoming token flit |
| q_nonempty | input | 1 | The transmit queue has a flit ready |
| tx_en | output | 1 | Drive the channel with one data flit this cycle |
| tok_out_valid | output | 1 | Outgoing token flit valid |
| tok_out_flit | output | 32 | Outgoing token flit |
| holding | output | 1 | This node holds the token |

## Verification
The proportional share is exercised with four demand vectors:
- an uneven vector whose division is exact;
- a vector received while holding, where rounding leaves a remainder, which separates floor-plus-remainder from plain floor;
- an all-zero vector, which exercises the equal-split fallback;
- a vector that gives this node the whole budget.

A vector with a zero own demand and a queue that drains mid-hold exercise both early-release paths. Two flits are sent that must be ignored: one addressed to another node and one with the wrong type code. Every cycle the bench compares the expected slot count, handoff flit fields and holder status with a behavioural model. This shows off-by-one slot counting and stale-share latching as mismatches in the exact cycle where they occur.

// File: rtl/tra_pkg.sv
package tra_pkg;
    typedef enum logic [1:0] {
        ST_WAIT    = 2'd0,
        ST_SEND    = 2'd1,
        ST_RELEASE = 2'd2
    } tok_state_e;

    localparam logic [3:0] TOKEN_CODE = 4'hA;
endpackage

// File: rtl/tra_share_calc.sv
module tra_share_calc #(
    parameter int N      = 12,
    parameter int DEM_W  = 8,
    parameter int PERIOD = 96,
    parameter int SLOT_W = 7,
    parameter int MY_ID  = 0
) (
    input  logic [N*DEM_W-1:0] dem_vec,
    output logic [SLOT_W-1:0]  own_share,
    output logic [SLOT_W-1:0]  leftover
);
    localparam int SUM_W  = DEM_W + $clog2(N + 1);
    localparam int PROD_W = DEM_W + SLOT_W;
    localparam int ACC_W  = SLOT_W + $clog2(N + 1);

    logic [SUM_W-1:0]  dsum;
    logic [SLOT_W-1:0] share [N];
    logic [ACC_W-1:0]  acc;

    // total demand over the ring
    always_comb begin
        dsum = '0;
        for (int i = 0; i < N; i++) begin
            dsum = dsum + SUM_W'(dem_vec[i*DEM_W +: DEM_W]);
        end
    end

    // one rounded-down share per ring member
    for (genvar g = 0; g < N; g++) begin : g_share
        logic [PROD_W-1:0] prod;
        assign prod = PROD_W'(PERIOD) * PROD_W'(dem_vec[g*DEM_W +: DEM_W]);
        assign share[g] = (dsum == '0) ? SLOT_W'(PERIOD / N)
                                       : SLOT_W'(prod / PROD_W'(dsum));
    end

    // slots lost to rounding
    always_comb begin
        acc = '0;
        for (int i = 0; i < N; i++) begin
            acc = acc + ACC_W'(share[i]);
        end
        leftover = SLOT_W'(ACC_W'(PERIOD) - acc);
    end

    assign own_share = share[MY_ID];
endmodule

// File: rtl/tra_slot_fsm.sv
module tra_slot_fsm
    import tra_pkg::*;
#(
    parameter int SLOT_W      = 7,
    parameter int RESET_ALLOC = 8,
    parameter bit START_HOLD  = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              grant,
    input  logic [SLOT_W-1:0] alloc,
    input  logic              q_nonempty,
    output logic              tx_en,
    output logic              release_o,
    output logic              holding,
    output logic [SLOT_W-1:0] used_cnt
);
    tok_state_e        state, state_nx;
    logic [SLOT_W-1:0] budget;

    // next-state selection
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_WAIT:    if (grant) state_nx = ST_SEND;
            ST_SEND:    if (used_cnt >= budget || !q_nonempty) state_nx = ST_RELEASE;
            ST_RELEASE: state_nx = ST_WAIT;
            default:    state_nx = ST_WAIT;
        endcase
    end

    // state, latched share and slot counter
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= START_HOLD ? ST_SEND : ST_WAIT;
            budget   <= SLOT_W'(RESET_ALLOC);
            used_cnt <= '0;
        end else begin
            state <= state_nx;
            if (state == ST_WAIT && grant) begin
                budget   <= alloc;
                used_cnt <= '0;
            end else if (tx_en) begin
                used_cnt <= used_cnt + 1'b1;
            end
        end
    end

    // outputs
    always_comb begin
        tx_en     = (state == ST_SEND) && (used_cnt < budget) && q_nonempty;
        release_o = (state == ST_RELEASE);
        holding   = (state != ST_WAIT);
    end

    a_r8_used_bound: assert property (@(posedge clk) disable iff (!rst_n)
        used_cnt <= budget);

    a_r10_empty_releases: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SEND && !q_nonempty) |=> (state == ST_RELEASE));
endmodule

// File: rtl/token_ring_arbiter.sv
module token_ring_arbiter
    import tra_pkg::*;
#(
    parameter int N      = 12,
    parameter int FLIT_W = 32,
    parameter int DEM_W  = 8,
    parameter int PERIOD = 96,
    parameter int MY_ID  = 0
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                dem_valid,
    input  logic [N*DEM_W-1:0]  dem_vec,
    input  logic                tok_in_valid,
    input  logic [FLIT_W-1:0]   tok_in_flit,
    input  logic                q_nonempty,
    output logic                tx_en,
    output logic                tok_out_valid,
    output logic [FLIT_W-1:0]   tok_out_flit,
    output logic                holding
);
    localparam int ID_W        = $clog2(N);
    localparam int SLOT_W      = $clog2(PERIOD + 1);
    localparam int EQ_SHARE    = PERIOD / N;
    localparam int EQ_LEFT     = PERIOD - N * EQ_SHARE;
    localparam int RESET_ALLOC = EQ_SHARE + ((MY_ID == 0) ? EQ_LEFT : 0);
    localparam int NEXT_ID     = (MY_ID + 1) % N;
    localparam int SRC_LO      = 0;
    localparam int DST_LO      = ID_W;
    localparam int CNT_LO      = 2 * ID_W;
    localparam int TYPE_LO     = FLIT_W - 4;

    logic [ID_W-1:0]   in_dst;
    logic [3:0]        in_code;
    logic              tok_seen, grant, release_w;
    logic [ID_W-1:0]   holder_q;
    logic [SLOT_W-1:0] alloc_q, own_share, leftover, used_cnt;
    logic              unused_flit_bits;

    assign in_dst           = tok_in_flit[DST_LO +: ID_W];
    assign in_code          = tok_in_flit[TYPE_LO +: 4];
    assign tok_seen         = tok_in_valid && (in_code == TOKEN_CODE);
    assign grant            = tok_seen && (in_dst == ID_W'(MY_ID));
    assign unused_flit_bits = ^tok_in_flit;

    tra_share_calc #(
        .N(N), .DEM_W(DEM_W), .PERIOD(PERIOD), .SLOT_W(SLOT_W), .MY_ID(MY_ID)
    ) u_share (
        .dem_vec   (dem_vec),
        .own_share (own_share),
        .leftover  (leftover)
    );

    tra_slot_fsm #(
        .SLOT_W(SLOT_W), .RESET_ALLOC(RESET_ALLOC), .START_HOLD(MY_ID == 0)
    ) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .grant      (grant),
        .alloc      (alloc_q),
        .q_nonempty (q_nonempty),
        .tx_en      (tx_en),
        .release_o  (release_w),
        .holding    (holding),
        .used_cnt   (used_cnt)
    );

    // recorded holder and next-hold share
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            holder_q <= '0;
            alloc_q  <= SLOT_W'(RESET_ALLOC);
        end else begin
            if (release_w)
                holder_q <= ID_W'(NEXT_ID);
            else if (tok_seen && !holding)
                holder_q <= in_dst;
            if (dem_valid)
                alloc_q <= own_share +
                           ((holder_q == ID_W'(MY_ID)) ? leftover : '0);
        end
    end

    // handoff flit
    always_comb begin
        tok_out_valid = release_w;
        tok_out_flit  = '0;
        if (release_w) begin
            tok_out_flit[TYPE_LO +: 4]    = TOKEN_CODE;
            tok_out_flit[SRC_LO +: ID_W]  = ID_W'(MY_ID);
            tok_out_flit[DST_LO +: ID_W]  = ID_W'(NEXT_ID);
            tok_out_flit[CNT_LO +: SLOT_W] = used_cnt;
        end
    end

    a_r4_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        tok_out_valid |=> !tok_out_valid);

    a_r2_tx_while_holding: assert property (@(posedge clk) disable iff (!rst_n)
        tx_en |-> holding);

    a_r3_rise_needs_grant: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(holding) |-> $past(grant));

    a_r6_holder_consistent: assert property (@(posedge clk) disable iff (!rst_n)
        holding == (holder_q == ID_W'(MY_ID)));

    a_r5_share_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        dem_valid |=> (alloc_q <= SLOT_W'(PERIOD)));
endmodule

// File: tb/sim_token_ring_arbiter.sv
`timescale 1ns/1ps
module sim_token_ring_arbiter;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        dem_valid = 1'b0;
    logic [95:0] dem_vec = '0;
    logic        tok_in_valid = 1'b0;
    logic [31:0] tok_in_flit = '0;
    logic        q_nonempty = 1'b1;
    logic        tx_en, tok_out_valid, holding;
    logic [31:0] tok_out_flit;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    int dm [12];

    // behavioural model state
    int m_st = 1;
    int m_budget = 8;
    int m_used = 0;
    int m_alloc = 8;
    int m_holder = 0;

    always #2 clk = ~clk;

    token_ring_arbiter u0 (
        .clk(clk), .rst_n(rst_n), .dem_valid(dem_valid), .dem_vec(dem_vec),
        .tok_in_valid(tok_in_valid), .tok_in_flit(tok_in_flit),
        .q_nonempty(q_nonempty), .tx_en(tx_en), .tok_out_valid(tok_out_valid),
        .tok_out_flit(tok_out_flit), .holding(holding)
    );

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 20000) begin
            errors = errors + 1;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    function automatic int calc_share(input int holder);
        int sum = 0;
        int acc = 0;
        int f;
        int own = 0;
        for (int i = 0; i < 12; i++) sum += dm[i];
        for (int i = 0; i < 12; i++) begin
            f = (sum == 0) ? 96 / 12 : (96 * dm[i]) / sum;
            acc += f;
            if (i == 0) own = f;
        end
        return own + ((holder == 0) ? (96 - acc) : 0);
    endfunction

    task automatic check(input string tag, input int got, input int exp);
        checks = checks + 1;
        if (got != exp) begin
            errors = errors + 1;
            $display("FAIL %s got %0h expected %0h", tag, got, exp);
        end
    endtask

    task automatic step(input string tag);
        int e_tx, e_v, e_flit, e_hold;
        int code, dst, nst, nalloc, nholder;
        bit seen, grant;
        #1;
        e_tx   = (m_st == 1 && m_used < m_budget && q_nonempty) ? 1 : 0;
        e_v    = (m_st == 2) ? 1 : 0;
        e_flit = e_v ? (32'hA000_0010 | (m_used << 8)) : 0;
        e_hold = (m_st != 0) ? 1 : 0;
        check({tag, " R8 tx_en"}, int'(tx_en), e_tx);
        check({tag, " R4 tok_out_valid"}, int'(tok_out_valid), e_v);
        check({tag, " R4 tok_out_flit"}, int'(tok_out_flit), e_flit);
        check({tag, " R2 holding"}, int'(holding), e_hold);
        // model update
        code  = int'(tok_in_flit[31:28]);
        dst   = int'(tok_in_flit[7:4]);
        seen  = tok_in_valid && code == 10;
        grant = seen && dst == 0;
        nalloc  = dem_valid ? calc_share(m_holder) : m_alloc;
        nholder = m_holder;
        if (m_st == 2) nholder = 1;
        else if (seen && m_st == 0) nholder = dst;
        nst = m_st;
        case (m_st)
            0: if (grant) begin nst = 1; m_budget = m_alloc; m_used = 0; end
            1: if (m_used >= m_budget || !q_nonempty) nst = 2;
               else m_used = m_used + 1;
            default: nst = 0;
        endcase
        m_st = nst; m_alloc = nalloc; m_holder = nholder;
        @(negedge clk);
    endtask

    task automatic run(input int n, input string tag);
        for (int k = 0; k < n; k++) step(tag);
    endtask

    task automatic send_dem(input string tag);
        for (int i = 0; i < 12; i++) dem_vec[i*8 +: 8] = dm[i][7:0];
        dem_valid = 1'b1;
        step(tag);
        dem_valid = 1'b0;
    endtask

    task automatic send_tok(input logic [31:0] f, input string tag);
        tok_in_flit = f; tok_in_valid = 1'b1;
        step(tag);
        tok_in_valid = 1'b0; tok_in_flit = '0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset share of 8 for node 0, then handoff
        run(12, "R1");
        // R3: flit for node 5 and flit with wrong code are ignored
        send_tok(32'hA000_0050, "R3 other dst");
        run(2, "R3");
        send_tok(32'hB000_0005, "R3 bad code");
        run(2, "R3");
        // R5: uneven exact split, own share 32
        dm[0] = 30; dm[1] = 10;
        for (int i = 2; i < 12; i++) dm[i] = 5;
        send_dem("R5");
        send_tok(32'hA000_000B, "R5 grant");
        run(40, "R5");
        // R6: vector during hold adds remainder (22 + 5), applies next hold
        send_tok(32'hA000_000B, "R6 grant");
        run(3, "R6");
        dm[0] = 7; dm[1] = 3;
        for (int i = 2; i < 12; i++) dm[i] = 2;
        send_dem("R6 R8 during hold");
        run(35, "R8 old share");
        send_tok(32'hA000_000B, "R6 grant2");
        run(32, "R6 new share");
        // R10: queue drains after 5 slots
        send_tok(32'hA000_000B, "R10 grant");
        run(5, "R10");
        q_nonempty = 1'b0;
        run(3, "R10 drained");
        q_nonempty = 1'b1;
        // R7: all-zero vector gives equal split
        for (int i = 0; i < 12; i++) dm[i] = 0;
        send_dem("R7");
        send_tok(32'hA000_000B, "R7 grant");
        run(12, "R7");
        // R9: zero own demand
        dm[1] = 50;
        send_dem("R9");
        send_tok(32'hA000_000B, "R9 grant");
        run(4, "R9");
        // R5: whole budget to this node
        for (int i = 0; i < 12; i++) dm[i] = 0;
        dm[0] = 255;
        send_dem("R5 full");
        send_tok(32'hA000_000B, "R5 full grant");
        run(100, "R5 full");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule